// File: doc/BRIEF.md
# Decimal Coefficient Rounding Unit

This block shortens a decimal coefficient held as a plain unsigned binary integer. A request carries a coefficient `C` of at most `DIGITS` decimal digits and a count `x` of low-order decimal digits to drop. The block returns `floor(C / 10^x)` rounded to nearest with ties going to the even neighbour. It also returns two flags. One says the dropped digits were not all zero. The other says they were exactly one half of a unit in the last kept place. A third signal reports that the rounding step produced one digit more than the target precision `DIGITS - x`. A later stage then rescales the result and adjusts the exponent.

The block has no divider. A small constant table is computed when the design is elaborated. For each `x` it holds an integer `Kx = ceil(2^E / 10^x)`, where one exponent `E` is shared by all entries. `E` is the smallest value with `2^E >= 10^(2*DIGITS)`. The product `C * Kx` gives the truncated quotient in its bits at `E` and above. Its low `E` bits act as a fixed-point fraction. Comparing that fraction with `Kx`, with `2^(E-1)` and with `2^(E-1) + Kx` sorts the discarded part into four classes: zero, below half, exactly half, above half. No remainder is ever formed.

Control is a three-state machine. `ST_IDLE` raises `in_ready`. An accepted request (`in_valid` high in `ST_IDLE`) moves it to `ST_CALC`, and the operands are registered on that move. `ST_CALC` always moves to `ST_HOLD` after one cycle and registers the result. `ST_HOLD` raises `out_valid` and stays there until `out_ready` is seen high, then returns to `ST_IDLE`. Requests with `C >= 10^DIGITS` or `x > DIGITS` lie outside the contract.

Top module: `dcr_round_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: The returned coefficient is `H = floor(C / 10^x)` whenever the discarded part is below one half (for `DIGITS` = 3 and 19 alike).
- R3: When `C mod 10^x = 0`, `out_inexact` and `out_tie` are both 0 and `out_coef = C / 10^x`.
- R4: When `0 < C mod 10^x < 10^x/2`, `out_coef = H`, `out_inexact` = 1 and `out_tie` = 0.
- R5: When `C mod 10^x = 10^x/2`, `out_tie` = 1, `out_inexact` = 1, and `out_coef` is `H` if `H` is even and `H+1` if `H` is odd.
- R6: When `C mod 10^x > 10^x/2`, `out_coef = H+1`, `out_inexact` = 1 and `out_tie` = 0.
- R7: `out_carry` is 1 exactly when `x > 0` and the rounded result equals `10^(DIGITS-x)`; `out_coef` then holds that power of ten.
- R8: With `x = 0` the coefficient is returned unchanged, with `out_inexact`, `out_tie` and `out_carry` all 0.
- R9: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 0 after the first following edge and 1 after the second, and `in_ready` stays 0 until the result is taken.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_coef` and the three flags keep their values.
- R11: Each accepted request yields exactly one result. After the edge where `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1.
- R12: With `DIGITS` = 19, `C` = 1234567890123456789 and `x` = 3 give `out_coef` = 1234567890123457 with `out_inexact` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request (ST_IDLE) |
| in_coef | input | CW | Coefficient C as a binary integer, CW = bits of 10^DIGITS - 1 |
| in_drop | input | XW | Number of decimal digits to drop, XW = clog2(DIGITS+1) |
| out_valid | output | 1 | Result present (ST_HOLD) |
| out_ready | input | 1 | Consumer takes the result |
| out_coef | output | CW | Rounded quotient |
| out_carry | output | 1 | Rounded quotient reached 10^(DIGITS-x) |
| out_inexact | output | 1 | Discarded digits were not all zero |
| out_tie | output | 1 | Discarded part was exactly one half |

## Verification
A three-digit instance is swept over every coefficient and every drop count from zero up to the full width. This reaches each tie, including a tie whose truncated quotient is zero. A threshold off by one unit would misclassify these ties as below or above half, and a tie rule with the parity inverted would round even quotients upward. The sweep also covers values such as 999 with one digit dropped and 501 with all digits dropped, where rounding creates a new leading digit. A wrong power-of-ten limit would miss the carry there or raise it falsely. A nineteen-digit instance checks that the shared-exponent constants stay exact at full scale, near the top of the range, on an exact tie, and on the case that drops every digit. Some transactions hold `out_ready` low to catch a result register that changes during a stall.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    // Working width of elaboration-time arithmetic; covers DIGITS up to about 70.
    localparam int MAXW = 512;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_HOLD
    } fsm_t;

    // Position of the discarded part relative to one half unit.
    typedef enum logic [1:0] {
        FC_ZERO,
        FC_BELOW,
        FC_TIE,
        FC_ABOVE
    } frac_cls_t;

    function automatic logic [MAXW-1:0] pow10(input int n);
        logic [MAXW-1:0] v;
        v = MAXW'(1);
        for (int i = 0; i < n; i++) begin
            v = v * MAXW'(10);
        end
        return v;
    endfunction

    // Bits needed to hold any value below 10^d.
    function automatic int coef_bits(input int d);
        logic [MAXW-1:0] v;
        int b;
        v = pow10(d) - MAXW'(1);
        b = 0;
        while (v != '0) begin
            v = v >> 1;
            b++;
        end
        if (b == 0) b = 1;
        return b;
    endfunction

    // Shared fraction exponent: smallest E with 2^E >= 10^(2d).
    function automatic int frac_bits(input int d);
        logic [MAXW-1:0] t;
        logic [MAXW-1:0] v;
        int e;
        t = pow10(2 * d);
        v = MAXW'(1);
        e = 0;
        while (v < t) begin
            v = v << 1;
            e++;
        end
        return e;
    endfunction

    // Reciprocal of 10^x scaled by 2^e, rounded up (elaboration time only).
    function automatic logic [MAXW-1:0] recip(input int e, input int x);
        logic [MAXW-1:0] p;
        logic [MAXW-1:0] s;
        p = pow10(x);
        s = MAXW'(1) << e;
        return (s + p - MAXW'(1)) / p;
    endfunction

endpackage

// File: rtl/dcr_const_rom.sv
module dcr_const_rom #(
    parameter int DIGITS = 34,
    parameter int XW     = 6,
    parameter int CW     = 113,
    parameter int E      = 226,
    parameter int KW     = 227
) (
    input  logic [XW-1:0] drop,
    output logic [KW-1:0] kmul,
    output logic [CW:0]   limit
);

    localparam int NENT = DIGITS + 1;

    logic [KW-1:0] k_tab   [NENT];
    logic [CW:0]   lim_tab [NENT];

    // One entry per legal drop count, built from the package functions.
    for (genvar i = 0; i < NENT; i++) begin : g_ent
        assign k_tab[i] = KW'(dcr_pkg::recip(E, i));
        if (i == 0) begin : g_nolim
            // No carry is possible when nothing is dropped.
            assign lim_tab[i] = '1;
        end else begin : g_lim
            assign lim_tab[i] = (CW + 1)'(dcr_pkg::pow10(DIGITS - i));
        end
    end

    assign kmul  = k_tab[drop];
    assign limit = lim_tab[drop];

endmodule

// File: rtl/dcr_classify.sv
module dcr_classify #(
    parameter int CW = 113,
    parameter int E  = 226,
    parameter int KW = 227
) (
    input  logic [CW-1:0]         coef,
    input  logic [KW-1:0]         kmul,
    output logic [CW-1:0]         quot,
    output dcr_pkg::frac_cls_t    cls
);

    // C*Kx < 10^DIGITS * 2^E <= 2^(CW+E): the product fits exactly.
    localparam int PW = CW + E;
    localparam logic [KW-1:0] HALF = KW'(1) << (E - 1);

    logic [PW-1:0] prod;
    logic [E-1:0]  frac;
    logic [KW-1:0] frac_x;
    logic [KW-1:0] tie_top;

    assign prod    = PW'(coef) * PW'(kmul);
    assign quot    = prod[E +: CW];
    assign frac    = prod[E-1:0];
    assign frac_x  = {1'b0, frac};
    assign tie_top = HALF + kmul;

    // The error term C*(Kx - 2^E/10^x) stays below Kx, so it never
    // crosses a class boundary.
    always_comb begin
        if (frac_x < kmul) begin
            cls = dcr_pkg::FC_ZERO;
        end else if (frac_x < HALF) begin
            cls = dcr_pkg::FC_BELOW;
        end else if (frac_x < tie_top) begin
            cls = dcr_pkg::FC_TIE;
        end else begin
            cls = dcr_pkg::FC_ABOVE;
        end
    end

endmodule

// File: rtl/dcr_rounder.sv
module dcr_rounder #(
    parameter int CW = 113
) (
    input  logic [CW-1:0]       quot,
    input  dcr_pkg::frac_cls_t  cls,
    input  logic [CW:0]         limit,
    output logic [CW-1:0]       coef,
    output logic                carry,
    output logic                inexact,
    output logic                tie
);

    logic bump;

    always_comb begin
        unique case (cls)
            dcr_pkg::FC_ZERO:  bump = 1'b0;
            dcr_pkg::FC_BELOW: bump = 1'b0;
            dcr_pkg::FC_TIE:   bump = quot[0];
            dcr_pkg::FC_ABOVE: bump = 1'b1;
            default:           bump = 1'b0;
        endcase
    end

    assign coef    = quot + CW'(bump);
    assign inexact = (cls != dcr_pkg::FC_ZERO);
    assign tie     = (cls == dcr_pkg::FC_TIE);
    assign carry   = ({1'b0, coef} == limit);

endmodule

// File: rtl/dcr_round_unit.sv
module dcr_round_unit #(
    parameter int DIGITS = 34,
    localparam int CW = dcr_pkg::coef_bits(DIGITS),
    localparam int XW = $clog2(DIGITS + 1),
    localparam int E  = dcr_pkg::frac_bits(DIGITS),
    localparam int KW = E + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [CW-1:0] in_coef,
    input  logic [XW-1:0] in_drop,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [CW-1:0] out_coef,
    output logic          out_carry,
    output logic          out_inexact,
    output logic          out_tie
);

    dcr_pkg::fsm_t st, st_nx;

    logic [CW-1:0] c_q;
    logic [XW-1:0] x_q;
    logic [XW-1:0] x_idx;
    logic [CW-1:0] o_coef;
    logic          o_carry, o_inexact, o_tie;

    logic [KW-1:0]       kmul;
    logic [CW:0]         limit;
    logic [CW-1:0]       cls_quot;
    dcr_pkg::frac_cls_t  cls;
    logic [CW-1:0]       rnd_coef;
    logic                rnd_carry, rnd_inexact, rnd_tie;

    // Out-of-contract drop counts are clamped so the table index stays legal.
    assign x_idx = (int'(x_q) > DIGITS) ? XW'(DIGITS) : x_q;

    dcr_const_rom #(.DIGITS(DIGITS), .XW(XW), .CW(CW), .E(E), .KW(KW)) u_rom (
        .drop  (x_idx),
        .kmul  (kmul),
        .limit (limit)
    );

    dcr_classify #(.CW(CW), .E(E), .KW(KW)) u_cls (
        .coef (c_q),
        .kmul (kmul),
        .quot (cls_quot),
        .cls  (cls)
    );

    dcr_rounder #(.CW(CW)) u_rnd (
        .quot    (cls_quot),
        .cls     (cls),
        .limit   (limit),
        .coef    (rnd_coef),
        .carry   (rnd_carry),
        .inexact (rnd_inexact),
        .tie     (rnd_tie)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= dcr_pkg::ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            dcr_pkg::ST_IDLE: if (in_valid)  st_nx = dcr_pkg::ST_CALC;
            dcr_pkg::ST_CALC:                st_nx = dcr_pkg::ST_HOLD;
            dcr_pkg::ST_HOLD: if (out_ready) st_nx = dcr_pkg::ST_IDLE;
            default:                         st_nx = dcr_pkg::ST_IDLE;
        endcase
    end

    // Operand and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            x_q       <= '0;
            o_coef    <= '0;
            o_carry   <= 1'b0;
            o_inexact <= 1'b0;
            o_tie     <= 1'b0;
        end else begin
            if (st == dcr_pkg::ST_IDLE && in_valid) begin
                c_q <= in_coef;
                x_q <= in_drop;
            end
            if (st == dcr_pkg::ST_CALC) begin
                o_coef    <= rnd_coef;
                o_carry   <= rnd_carry;
                o_inexact <= rnd_inexact;
                o_tie     <= rnd_tie;
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready    = (st == dcr_pkg::ST_IDLE);
        out_valid   = (st == dcr_pkg::ST_HOLD);
        out_coef    = o_coef;
        out_carry   = o_carry;
        out_inexact = o_inexact;
        out_tie     = o_tie;
    end

    // R9
    accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !out_valid && !in_ready ##1 out_valid);

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_coef)
            && $stable(out_carry) && $stable(out_inexact) && $stable(out_tie));

    // R11
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && in_ready);

    // R8
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && x_q == '0 |-> out_coef == c_q && !out_inexact
            && !out_tie && !out_carry);

    // R5
    tie_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_tie |-> out_inexact);

    // R7
    carry_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_carry |-> out_inexact && x_q != '0);

    // R6
    round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == dcr_pkg::ST_CALC |-> rnd_coef == cls_quot
            || rnd_coef == cls_quot + CW'(1));

    // R2
    quot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == dcr_pkg::ST_CALC |-> cls_quot <= c_q);

endmodule

// File: tb/sim_dcr_round_unit.sv
module sim_dcr_round_unit;

    localparam int CLK_NS = 10;
    localparam int D0  = 3;
    localparam int D1  = 19;
    localparam int CW0 = dcr_pkg::coef_bits(D0);
    localparam int XW0 = $clog2(D0 + 1);
    localparam int CW1 = dcr_pkg::coef_bits(D1);
    localparam int XW1 = $clog2(D1 + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic           vld0 = 1'b0, rdy0, ov0, ordy0 = 1'b0, ocy0, oix0, otie0;
    logic [CW0-1:0] c0 = '0, oc0;
    logic [XW0-1:0] x0 = '0;

    logic           vld1 = 1'b0, rdy1, ov1, ordy1 = 1'b0, ocy1, oix1, otie1;
    logic [CW1-1:0] c1 = '0, oc1;
    logic [XW1-1:0] x1 = '0;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    dcr_round_unit #(.DIGITS(D0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(vld0), .in_ready(rdy0),
        .in_coef(c0), .in_drop(x0), .out_valid(ov0), .out_ready(ordy0),
        .out_coef(oc0), .out_carry(ocy0), .out_inexact(oix0), .out_tie(otie0)
    );

    dcr_round_unit #(.DIGITS(D1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(vld1), .in_ready(rdy1),
        .in_coef(c1), .in_drop(x1), .out_valid(ov1), .out_ready(ordy1),
        .out_coef(oc1), .out_carry(ocy1), .out_inexact(oix1), .out_tie(otie1)
    );

    task automatic check(input bit ok, input string req, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    // Reference rounding by plain division and remainder.
    task automatic expect_of(input logic [127:0] c, input int x, input int d,
                             output logic [127:0] r, output bit cy,
                             output bit ix, output bit md, output string tag);
        logic [127:0] p, h, l, lim;
        bit up;
        p = 128'd1;
        for (int i = 0; i < x; i++) p = p * 128'd10;
        lim = 128'd1;
        for (int i = 0; i < d - x; i++) lim = lim * 128'd10;
        h  = c / p;
        l  = c % p;
        ix = (l != 0);
        md = (2 * l == p);
        up = (2 * l > p) || (md && h[0]);
        r  = h + 128'(up);
        cy = (x > 0) && (r == lim);
        if (x == 0)       tag = "R8";
        else if (cy)      tag = "R7";
        else if (!ix)     tag = "R3";
        else if (md)      tag = "R5";
        else if (up)      tag = "R6";
        else              tag = "R2 R4";
    endtask

    task automatic run0(input int c, input int x, input bit stall);
        logic [127:0] er;
        bit ecy, eix, emd;
        string tag;
        logic [CW0-1:0] hc;
        logic [2:0] hf;
        expect_of(128'(c), x, D0, er, ecy, eix, emd, tag);
        while (!rdy0) @(negedge clk);
        vld0 = 1'b1; c0 = CW0'(c); x0 = XW0'(x);
        @(negedge clk);
        vld0 = 1'b0;
        check(!ov0 && !rdy0, "R9", $sformatf("ov=%0b rdy=%0b", ov0, rdy0), "ov=0 rdy=0");
        @(negedge clk);
        check(ov0 && !rdy0, "R9", $sformatf("ov=%0b rdy=%0b", ov0, rdy0), "ov=1 rdy=0");
        if (stall) begin
            hc = oc0; hf = {ocy0, oix0, otie0};
            @(negedge clk);
            @(negedge clk);
            check(ov0 && oc0 == hc && {ocy0, oix0, otie0} == hf, "R10",
                  $sformatf("ov=%0b coef=%0d fl=%b", ov0, oc0, {ocy0, oix0, otie0}),
                  $sformatf("ov=1 coef=%0d fl=%b", hc, hf));
        end
        check(oc0 == er[CW0-1:0] && ocy0 == ecy && oix0 == eix && otie0 == emd, tag,
              $sformatf("C=%0d x=%0d coef=%0d cy=%0b ix=%0b tie=%0b", c, x, oc0, ocy0, oix0, otie0),
              $sformatf("coef=%0d cy=%0b ix=%0b tie=%0b", er, ecy, eix, emd));
        ordy0 = 1'b1;
        @(negedge clk);
        ordy0 = 1'b0;
        check(!ov0 && rdy0, "R11", $sformatf("ov=%0b rdy=%0b", ov0, rdy0), "ov=0 rdy=1");
    endtask

    task automatic run1(input logic [63:0] c, input int x, input string extra);
        logic [127:0] er;
        bit ecy, eix, emd;
        string tag;
        expect_of(128'(c), x, D1, er, ecy, eix, emd, tag);
        while (!rdy1) @(negedge clk);
        vld1 = 1'b1; c1 = CW1'(c); x1 = XW1'(x);
        @(negedge clk);
        vld1 = 1'b0;
        @(negedge clk);
        check(ov1 && oc1 == er[CW1-1:0] && ocy1 == ecy && oix1 == eix && otie1 == emd,
              {extra, tag},
              $sformatf("C=%0d x=%0d ov=%0b coef=%0d cy=%0b ix=%0b tie=%0b",
                        c, x, ov1, oc1, ocy1, oix1, otie1),
              $sformatf("ov=1 coef=%0d cy=%0b ix=%0b tie=%0b", er, ecy, eix, emd));
        ordy1 = 1'b1;
        @(negedge clk);
        ordy1 = 1'b0;
        check(!ov1 && rdy1, "R11", $sformatf("ov=%0b rdy=%0b", ov1, rdy1), "ov=0 rdy=1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: state during reset
        check(rdy0 && !ov0 && rdy1 && !ov1, "R1",
              $sformatf("rdy=%0b ov=%0b", rdy0, ov0), "rdy=1 ov=0");
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdy0 && !ov0, "R1", $sformatf("rdy=%0b ov=%0b", rdy0, ov0), "rdy=1 ov=0");

        // Exhaustive sweep of the three-digit instance (R2..R11)
        for (int x = 0; x <= D0; x++) begin
            for (int c = 0; c < 1000; c++) begin
                run0(c, x, (c % 37) == x);
            end
        end

        // Nineteen-digit instance
        run1(64'd1234567890123456789, 3, "R12 ");
        run1(64'd1234567890123456500, 3, "R12 ");
        run1(64'd1234567890123457500, 3, "R12 ");
        run1(64'd9999999999999999999, 3, "R12 ");
        run1(64'd5000000000000000000, 19, "R12 ");
        run1(64'd9999999999999999999, 0, "R12 ");
        run1(64'd1000000000000000000, 18, "R12 ");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule